// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 64-bit virtual address into a physical address by reading up to three levels of page tables from memory. Pages are 8 KB and each table level holds 1024 entries of eight bytes. A request carries the virtual address, an access kind (read, write, execute or probe) and a privilege (kernel, user or physical). The walker returns either a physical address with the granted read/write/execute permissions or a fault code.

Some requests are resolved before any table read. Physical-privilege requests pass straight through. Addresses that are not properly sign-extended are refused. A kernel-only superpage window is mapped directly. All other requests start from a table base input and make one memory read at a time over a simple request/response interface. The walker holds off new requests while a walk is in progress and reports each result with a one-cycle done pulse.

Top module: `pt_walker`

## Requirements
- R1: While reset is high and in the cycle after reset, `busy`, `done` and `mem_req_valid` are low.
- R2: A request with `req_priv` bit 1 set (physical) finishes with no memory read. It returns `phys_addr` equal to `req_vaddr` and `perm` = 3'b111, where bit 0 is read, bit 1 is write and bit 2 is execute.
- R3: If bits [63:43] of the address are not all equal, the request is refused with access violation (code 1) and no memory read is made.
- R4: A negative address with bits [42:41] = 2'b10 is a superpage. For kernel privilege (0) it returns physical bits [39:0] from the virtual address, virtual bit 40 placed at physical bit 43, the other bits zero, and `perm` 3'b111, with no memory read. For user privilege (1) it returns access violation.
- R5: A walk reads the entry at `table_base` + index×8, where the indices are the address fields [42:33], [32:23] and [22:13]. The next table base is entry bits [63:32] shifted left by 13. Only one read is outstanding at a time, and a full walk makes exactly three reads.
- R6: At levels 1 and 2, a clear valid bit (entry bit 0) ends the walk with translation-not-valid (code 0). A set valid bit with a clear kernel-read bit (entry bit 8) ends it with access violation (code 1).
- R7: At level 3, a clear valid bit gives code 0. Read and execute are granted by entry bit 8 (kernel) or bit 9 (user). Write is granted by entry bit 12 (kernel) or bit 13 (user).
- R8: If none of the requested permissions is granted at level 3, the fault is access violation (code 1). Access codes are 0 read, 1 write, 2 execute, 3 probe.
- R9: Entry bits 1, 2 and 3 remove read, write and execute respectively from the granted set. If the request is then denied, the fault is fault-on-execute (code 3), fault-on-write (code 4) or fault-on-read (code 2), checked in that priority order.
- R10: A probe request (access 3) requires no permission. It succeeds at level 3 whenever the entry is valid and returns the masked permissions, which may be 3'b000.
- R11: While `busy` is high, `req_valid` is ignored. `done` is a single-cycle pulse, and exactly one pulse follows each accepted request.
- R12: A successful walk returns entry bits [63:32] concatenated with the 13-bit page offset. Any fault returns `phys_addr` = 0 and `perm` = 0 with `fault` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| table_base | input | 64 | Physical base address of the level-1 table |
| req_valid | input | 1 | Translation request strobe, taken when not busy |
| req_vaddr | input | 64 | Virtual address to translate |
| req_access | input | 2 | 0 read, 1 write, 2 execute, 3 probe |
| req_priv | input | 2 | 0 kernel, 1 user, 2 or 3 physical |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | One-cycle read request pulse |
| mem_req_addr | output | 64 | Address of the entry being read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry read from memory |
| done | output | 1 | Result valid pulse |
| fault | output | 1 | Result is a fault |
| fault_code | output | 3 | 0 not valid, 1 access violation, 2 fault-on-read, 3 fault-on-execute, 4 fault-on-write |
| phys_addr | output | 64 | Translated physical address |
| perm | output | 3 | Granted permissions: bit 0 read, bit 1 write, bit 2 execute |

## Verification
The assertions assume that `mem_rsp_valid` arrives only while a read is outstanding, once per request, and never in the same cycle as the request pulse. The bench's responder answers exactly one cycle after each request pulse and is otherwise silent. The bench raises `req_valid` for a single cycle and only when `busy` is low, except in the hold-off test, which deliberately strobes a request during a walk to show that it is ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    FLT_TNV = 3'd0,
    FLT_ACV = 3'd1,
    FLT_FOR = 3'd2,
    FLT_FOE = 3'd3,
    FLT_FOW = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_RD    = 2'd0,
    ACC_WR    = 2'd1,
    ACC_EX    = 2'd2,
    ACC_PROBE = 2'd3
  } access_e;

  // entry bit positions the walker decodes
  localparam int PTE_VALID = 0;
  localparam int PTE_FOR   = 1;
  localparam int PTE_FOW   = 2;
  localparam int PTE_FOE   = 3;
  localparam int PTE_KRD   = 8;
  localparam int PTE_KWR   = 12;

endpackage

// File: rtl/ptw_precheck.sv
module ptw_precheck
  import ptw_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter int IMPL_VA    = 43,
  parameter int SP_PA_BITS = 40,
  parameter int SP_MOVE_TO = 43
) (
  input  logic [VA_W-1:0] vaddr,
  input  logic [1:0]      priv,
  output logic            resolved,
  output logic            flt,
  output fault_e          code,
  output logic [VA_W-1:0] pa,
  output logic [2:0]      perm
);
  logic canon, super_pg, phys_mode;
  logic [VA_W-1:0] sp_pa;

  assign phys_mode = priv[1];
  assign canon     = (&vaddr[VA_W-1:IMPL_VA]) | ~(|vaddr[VA_W-1:IMPL_VA]);
  assign super_pg  = vaddr[VA_W-1] && (vaddr[IMPL_VA-1:IMPL_VA-2] == 2'b10);

  always_comb begin
    sp_pa = '0;
    sp_pa[SP_PA_BITS-1:0] = vaddr[SP_PA_BITS-1:0];
    sp_pa[SP_MOVE_TO]     = vaddr[SP_PA_BITS];
  end

  always_comb begin
    resolved = 1'b1;
    flt      = 1'b0;
    code     = FLT_TNV;
    pa       = '0;
    perm     = 3'b000;
    if (phys_mode) begin
      pa   = vaddr;
      perm = 3'b111;
    end else if (!canon) begin
      flt  = 1'b1;
      code = FLT_ACV;
    end else if (super_pg) begin
      if (priv != 2'd0) begin
        flt  = 1'b1;
        code = FLT_ACV;
      end else begin
        pa   = sp_pa;
        perm = 3'b111;
      end
    end else begin
      resolved = 1'b0;
    end
  end

  always_comb begin
    if (resolved && !flt) a_r4_sp_kernel_only: assert (phys_mode || priv == 2'd0);
  end
endmodule

// File: rtl/ptw_leaf_eval.sv
module ptw_leaf_eval
  import ptw_pkg::*;
#(
  parameter int PTE_W     = 64,
  parameter int PAGE_BITS = 13,
  parameter int PA_W      = 64
) (
  input  logic [PTE_W-1:0]     pte,
  input  logic [1:0]           access,
  input  logic                 user,
  input  logic [PAGE_BITS-1:0] offset,
  output logic                 flt,
  output fault_e               code,
  output logic [PA_W-1:0]      pa,
  output logic [2:0]           perm
);
  localparam int FRAME_W = PTE_W / 2;

  logic       rd_en, wr_en;
  logic [2:0] raw, masked, need;
  logic       unused_pte;

  assign rd_en  = pte[PTE_KRD + int'(user)];
  assign wr_en  = pte[PTE_KWR + int'(user)];
  assign raw    = {rd_en, wr_en, rd_en};           // X W R
  assign masked = raw & ~pte[PTE_FOE:PTE_FOR];
  assign unused_pte = ^{pte[FRAME_W-1:PTE_KWR+2], pte[PTE_KWR-1:PTE_KRD+2], pte[PTE_KRD-1:PTE_FOE+1]};

  always_comb begin
    unique case (access_e'(access))
      ACC_RD:  need = 3'b001;
      ACC_WR:  need = 3'b010;
      ACC_EX:  need = 3'b100;
      default: need = 3'b000;
    endcase
  end

  always_comb begin
    flt  = 1'b0;
    code = FLT_TNV;
    pa   = '0;
    perm = 3'b000;
    if (!pte[PTE_VALID]) begin
      flt = 1'b1;
    end else if (need != 3'b000 && (raw & need) == 3'b000) begin
      flt  = 1'b1;
      code = FLT_ACV;
    end else if (need != 3'b000 && (masked & need) == 3'b000) begin
      flt  = 1'b1;
      code = need[2] ? FLT_FOE : (need[1] ? FLT_FOW : FLT_FOR);
    end else begin
      pa[FRAME_W+PAGE_BITS-1:0] = {pte[PTE_W-1:FRAME_W], offset};
      perm = masked;
    end
  end

  always_comb begin
    a_r9_perm_subset: assert ((perm & ~raw) == 3'b000);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PA_W      = 64,
  parameter int PAGE_BITS = 13,
  parameter int IDX_BITS  = 10,
  parameter int LEVELS    = 3,
  parameter int PTE_BYTES = 8,
  parameter int IMPL_VA   = 43
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PA_W-1:0] table_base,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [1:0]      req_access,
  input  logic [1:0]      req_priv,
  output logic            busy,
  output logic            mem_req_valid,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            done,
  output logic            fault,
  output logic [2:0]      fault_code,
  output logic [PA_W-1:0] phys_addr,
  output logic [2:0]      perm
);
  localparam int ENT_SH  = $clog2(PTE_BYTES);
  localparam int LVL_W   = $clog2(LEVELS + 1);
  localparam int FRAME_W = 32;
  localparam int TOP_IDX = PAGE_BITS + IDX_BITS * LEVELS;

  typedef enum logic {S_IDLE, S_WAIT} state_e;

  state_e           state;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q, priv_q;
  logic [LVL_W-1:0] lvl_q;
  logic             unused_bits;

  assign unused_bits = ^{va_q[VA_W-1:TOP_IDX], priv_q[1]};

  function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] base,
                                                 input logic [VA_W-1:0] va,
                                                 input int lvl);
    logic [VA_W-1:0] sh;
    logic [PA_W-1:0] off;
    sh  = va >> (PAGE_BITS + IDX_BITS * (LEVELS - lvl));
    off = '0;
    off[IDX_BITS+ENT_SH-1:ENT_SH] = sh[IDX_BITS-1:0];
    return base + off;
  endfunction

  function automatic logic [PA_W-1:0] next_base(input logic [63:0] pte);
    logic [PA_W-1:0] b;
    b = '0;
    b[FRAME_W+PAGE_BITS-1:PAGE_BITS] = pte[63:32];
    return b;
  endfunction

  // checks resolved without a walk
  logic            pre_res, pre_flt;
  fault_e          pre_code;
  logic [VA_W-1:0] pre_pa;
  logic [2:0]      pre_perm;

  ptw_precheck #(
    .VA_W(VA_W), .IMPL_VA(IMPL_VA), .SP_PA_BITS(40), .SP_MOVE_TO(43)
  ) u_pre (
    .vaddr(req_vaddr), .priv(req_priv), .resolved(pre_res), .flt(pre_flt),
    .code(pre_code), .pa(pre_pa), .perm(pre_perm)
  );

  // final-level evaluation
  logic            leaf_flt;
  fault_e          leaf_code;
  logic [PA_W-1:0] leaf_pa;
  logic [2:0]      leaf_perm;

  ptw_leaf_eval #(
    .PTE_W(64), .PAGE_BITS(PAGE_BITS), .PA_W(PA_W)
  ) u_leaf (
    .pte(mem_rsp_data), .access(acc_q), .user(priv_q[0]),
    .offset(va_q[PAGE_BITS-1:0]), .flt(leaf_flt), .code(leaf_code),
    .pa(leaf_pa), .perm(leaf_perm)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      busy          <= 1'b0;
      done          <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      fault         <= 1'b0;
      fault_code    <= 3'd0;
      phys_addr     <= '0;
      perm          <= 3'b000;
      va_q          <= '0;
      acc_q         <= 2'd0;
      priv_q        <= 2'd0;
      lvl_q         <= '0;
    end else begin
      done          <= 1'b0;
      mem_req_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            va_q   <= req_vaddr;
            acc_q  <= req_access;
            priv_q <= req_priv;
            if (pre_res) begin
              done       <= 1'b1;
              fault      <= pre_flt;
              fault_code <= pre_code;
              phys_addr  <= pre_pa;
              perm       <= pre_perm;
            end else begin
              busy          <= 1'b1;
              mem_req_valid <= 1'b1;
              mem_req_addr  <= entry_addr(table_base, req_vaddr, 1);
              lvl_q         <= LVL_W'(1);
              state         <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            if (lvl_q != LVL_W'(LEVELS)) begin
              if (!mem_rsp_data[PTE_VALID] || !mem_rsp_data[PTE_KRD]) begin
                done       <= 1'b1;
                busy       <= 1'b0;
                state      <= S_IDLE;
                fault      <= 1'b1;
                fault_code <= mem_rsp_data[PTE_VALID] ? FLT_ACV : FLT_TNV;
                phys_addr  <= '0;
                perm       <= 3'b000;
              end else begin
                mem_req_valid <= 1'b1;
                mem_req_addr  <= entry_addr(next_base(mem_rsp_data), va_q, int'(lvl_q) + 1);
                lvl_q         <= lvl_q + LVL_W'(1);
              end
            end else begin
              done       <= 1'b1;
              busy       <= 1'b0;
              state      <= S_IDLE;
              fault      <= leaf_flt;
              fault_code <= leaf_code;
              phys_addr  <= leaf_pa;
              perm       <= leaf_perm;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r11_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  a_r5_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);
  a_r5_req_in_walk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> busy);
  a_r5_walk_starts: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> mem_req_valid);
  a_r12_fault_clears: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (perm == 3'b000 && phys_addr == '0));
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] table_base = 64'h0001_0000;
  logic        req_valid = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_access = '0, req_priv = '0;
  logic        busy, mem_req_valid, mem_rsp_valid, done, fault;
  logic [63:0] mem_req_addr, mem_rsp_data, phys_addr;
  logic [2:0]  fault_code, perm;

  always #4 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst(rst), .table_base(table_base), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_access(req_access), .req_priv(req_priv),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .done(done),
    .fault(fault), .fault_code(fault_code), .phys_addr(phys_addr), .perm(perm)
  );

  logic [63:0] bmem [logic [63:0]];
  int nreq = 0, ndone = 0, total = 0, bad = 0;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid) begin
      nreq++;
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= bmem.exists(mem_req_addr) ? bmem[mem_req_addr] : 64'd0;
    end
    if (done) ndone++;
  end

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic run_req(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] pv);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_access = acc; req_priv = pv;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 50; k++) begin
      if (done) break;
      @(negedge clk);
    end
    chk("R11 done seen", {63'd0, done}, 64'd1);
  endtask

  // {va, access, priv, fault, code, phys, perm, reads}
  localparam int NV = 20;
  localparam logic [140:0] VECS [NV] = '{
    {64'h0000_0002_0100_00AB, 2'd0, 2'd0, 1'b0, 3'd0, 64'h2000AB, 3'd7, 2'd3}, // R5 R7
    {64'h0000_0002_0100_00AB, 2'd1, 2'd1, 1'b0, 3'd0, 64'h2000AB, 3'd7, 2'd3}, // R7 user
    {64'h0000_0002_0100_20AB, 2'd0, 2'd0, 1'b0, 3'd0, 64'h2020AB, 3'd5, 2'd3}, // R7
    {64'h0000_0002_0100_20AB, 2'd0, 2'd1, 1'b1, 3'd1, 64'h0,      3'd0, 2'd3}, // R8
    {64'h0000_0002_0100_20AB, 2'd1, 2'd0, 1'b1, 3'd1, 64'h0,      3'd0, 2'd3}, // R8
    {64'h0000_0002_0100_40AB, 2'd0, 2'd0, 1'b1, 3'd2, 64'h0,      3'd0, 2'd3}, // R9 read
    {64'h0000_0002_0100_40AB, 2'd1, 2'd0, 1'b1, 3'd4, 64'h0,      3'd0, 2'd3}, // R9 write
    {64'h0000_0002_0100_40AB, 2'd2, 2'd1, 1'b1, 3'd3, 64'h0,      3'd0, 2'd3}, // R9 exec
    {64'h0000_0002_0100_60AB, 2'd0, 2'd0, 1'b1, 3'd0, 64'h0,      3'd0, 2'd3}, // R7 invalid
    {64'h0000_0002_0100_80AB, 2'd0, 2'd0, 1'b0, 3'd0, 64'h2080AB, 3'd3, 2'd3}, // R9 mask
    {64'h0000_0002_0100_80AB, 2'd2, 2'd0, 1'b1, 3'd3, 64'h0,      3'd0, 2'd3}, // R9
    {64'h0000_0002_0100_40AB, 2'd3, 2'd0, 1'b0, 3'd0, 64'h2040AB, 3'd0, 2'd3}, // R10
    {64'h0000_0002_0100_60AB, 2'd3, 2'd0, 1'b1, 3'd0, 64'h0,      3'd0, 2'd3}, // R10 invalid
    {64'h0000_000A_0000_0000, 2'd0, 2'd0, 1'b1, 3'd0, 64'h0,      3'd0, 2'd1}, // R6 L1 tnv
    {64'h0000_000C_0000_0000, 2'd0, 2'd0, 1'b1, 3'd1, 64'h0,      3'd0, 2'd1}, // R6 L1 acv
    {64'h0000_0002_0380_0000, 2'd0, 2'd0, 1'b1, 3'd0, 64'h0,      3'd0, 2'd2}, // R6 L2 tnv
    {64'h0000_1000_0000_0000, 2'd0, 2'd0, 1'b1, 3'd1, 64'h0,      3'd0, 2'd0}, // R3
    {64'hFFFF_FD12_3456_7890, 2'd1, 2'd0, 1'b0, 3'd0, 64'h0000_0812_3456_7890, 3'd7, 2'd0}, // R4
    {64'hFFFF_FD12_3456_7890, 2'd0, 2'd1, 1'b1, 3'd1, 64'h0,      3'd0, 2'd0}, // R4 user
    {64'h1234_5678_9ABC_DEF0, 2'd1, 2'd2, 1'b0, 3'd0, 64'h1234_5678_9ABC_DEF0, 3'd7, 2'd0}  // R2
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bmem[64'h10008] = 64'h0000_0020_0000_0101;
    bmem[64'h10030] = 64'h0000_0000_0000_0001;
    bmem[64'h40010] = 64'h0000_0030_0000_0101;
    bmem[64'h60000] = 64'h0000_0100_0000_3301;
    bmem[64'h60008] = 64'h0000_0101_0000_0101;
    bmem[64'h60010] = 64'h0000_0102_0000_330F;
    bmem[64'h60018] = 64'h0000_0103_0000_3300;
    bmem[64'h60020] = 64'h0000_0104_0000_3309;

    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {63'd0, busy}, 64'd0);
    chk("R1 done in reset", {63'd0, done}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mem_req after reset", {63'd0, mem_req_valid}, 64'd0);
    chk("R1 busy after reset", {63'd0, busy}, 64'd0);

    for (int v = 0; v < NV; v++) begin
      logic [140:0] e;
      int n0;
      e  = VECS[v];
      n0 = nreq;
      run_req(e[140:77], e[76:75], e[74:73]);
      chk($sformatf("R12 vec%0d fault", v), {63'd0, fault}, {63'd0, e[72]});
      chk($sformatf("R9 vec%0d code", v), {61'd0, fault_code}, {61'd0, e[71:69]});
      chk($sformatf("R12 vec%0d phys", v), phys_addr, e[68:5]);
      chk($sformatf("R7 vec%0d perm", v), {61'd0, perm}, {61'd0, e[4:2]});
      chk($sformatf("R5 vec%0d reads", v), 64'(nreq - n0), {62'd0, e[1:0]});
      @(negedge clk);
      chk($sformatf("R11 vec%0d single done", v), {63'd0, done}, 64'd0);
    end

    // R11: a request strobed mid-walk is ignored
    begin
      int d0;
      d0 = ndone;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = 64'h0000_0002_0100_00AB; req_access = 2'd0; req_priv = 2'd0;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk("R11 busy during walk", {63'd0, busy}, 64'd1);
      req_valid = 1'b1; req_vaddr = 64'h0000_000A_0000_0000;
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 0; k < 50; k++) begin
        if (done) break;
        @(negedge clk);
      end
      chk("R11 first result kept", phys_addr, 64'h2000AB);
      chk("R11 first result no fault", {63'd0, fault}, 64'd0);
      repeat (10) @(negedge clk);
      chk("R11 one done per accepted request", 64'(ndone - d0), 64'd1);
    end

    // R1: reset in the middle of a walk
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 64'h0000_0002_0100_00AB; req_priv = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy cleared by reset", {63'd0, busy}, 64'd0);
    chk("R1 no request after reset", {63'd0, mem_req_valid}, 64'd0);
    chk("R1 no done after reset", {63'd0, done}, 64'd0);

    // R5: table base moved, same walk still resolves through the new base
    table_base = 64'h0008_0000;
    bmem[64'h80008] = 64'h0000_0020_0000_0101;
    run_req(64'h0000_0002_0100_00AB, 2'd0, 2'd0);
    chk("R5 relocated base", phys_addr, 64'h2000AB);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule